// File: doc/BRIEF.md
# Ethernet MAC Control Register Block with Duplex Consistency Monitor

This block is the software-visible control word file of an Ethernet MAC. A 32-bit host port writes and reads words by byte address, where the byte address shifted right by two selects the word. The words hold two station addresses, a 64-bit group hash table, and the general, receive, transmit, error-clear and management control words. A read-only status word shows the management data line. The station addresses, the hash table and the control words are also driven out as ports, for the frame filter and datapath next to this block.

Software runs the PHY management bus by bit-banging. Three bits of the management control word set the clock level, the data output value and the data output enable. The block also watches whether the MAC's full-duplex setting agrees with the duplex bit reported by the PHY. That bit is bit 11 of PHY register 18, and it arrives here on a pin. A consistency check runs after every receive-control write and after every management-control write that changes the clock level. The result updates a mismatch flag only while the MAC enable bit is set. Each change of the flag also gives a one-cycle pulse.

Top module: `macreg_dpx`

## Requirements
- R1: After synchronous reset, every stored word reads zero, the management clock, data output and output enable are low, and the mismatch flag and change pulse are low.
- R2: The word index is the byte address shifted right by two, and the two low address bits are ignored. Indices are: station 0 low 0, station 0 high 1, station 1 low 2, station 1 high 3, hash low 4, hash high 5, general control 6, receive control 7, transmit control 8, error clear 9, management control 10, status 11. Words 0 to 10 read back what was written, except as stated in R3.
- R3: A station address low word holds address bytes 0 to 3, with byte n in bits 8n+7:8n. The high word keeps bytes 4 and 5 in bits 15:0, and its bits 31:16 read zero. The exported 48-bit address has byte n at bits 8n+7:8n.
- R4: In management control, bit 2 drives the management clock, bit 1 the data output enable, and bit 0 the data output value. The pins follow from the clock edge that completes the write.
- R5: Status bit 0 is the data line level: the driven value while the enable is set, otherwise the `mdio_in` pin. Status bits 31:1 read zero, and writes to the status word have no effect.
- R6: A write to receive control, or a write to management control whose bit 2 differs from the stored bit 2, starts a check. On the second clock edge after the write, the flag becomes (receive control bit 7 != `phy_fdx`).
- R7: A check has no effect on the flag unless general control bit 0 is set.
- R8: A management-control write that leaves bit 2 unchanged starts no check, and neither do writes to any other word.
- R9: `dpx_changed` is high for exactly the one cycle after each clock edge that changes the flag. A check that confirms the current value gives no pulse.
- R10: Writes whose index is 12 or above, or whose byte address has any bit above bit 5 set, change nothing, and reads of them return zero.
- R11: The exported group table is the high hash word in bits 63:32 and the low hash word in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | 32 | Host read data (combinational) |
| mdio_in | input | 1 | Management data line as received |
| phy_fdx | input | 1 | PHY-reported full-duplex bit |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| sta0_addr | output | 48 | Station address 0 |
| sta1_addr | output | 48 | Station address 1 |
| grp_table | output | 64 | Group hash table |
| gen_ctrl | output | 32 | General control word |
| rx_ctrl | output | 32 | Receive control word |
| tx_ctrl | output | 32 | Transmit control word |
| dpx_mismatch | output | 1 | Duplex mismatch flag |
| dpx_changed | output | 1 | One-cycle pulse on each flag change |

## Verification
Assertions check on every cycle that the flag holds whenever no enabled check is pending. They check that an enabled check sets the flag to the compare of the MAC and PHY duplex bits, and that each change pulse matches a real flag change. They also check that the management clock follows each management write, that the upper status bits stay zero, and that undecoded writes leave every exported word unchanged. Other behaviours can only be shown by the bench's scenarios: the byte order of the station addresses, the aliasing cases of the address decode, a management write that keeps the clock level, and a check that confirms the current value without a pulse.

// File: rtl/macreg_pkg.sv
package macreg_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_STORED = 11;

    typedef enum logic [3:0] {
        IX_STA0_LO = 4'd0,
        IX_STA0_HI = 4'd1,
        IX_STA1_LO = 4'd2,
        IX_STA1_HI = 4'd3,
        IX_GRP_LO  = 4'd4,
        IX_GRP_HI  = 4'd5,
        IX_GEN     = 4'd6,
        IX_RXC     = 4'd7,
        IX_TXC     = 4'd8,
        IX_ERRC    = 4'd9,
        IX_MGMT    = 4'd10,
        IX_STAT    = 4'd11
    } reg_ix_e;

    localparam logic [3:0] IX_LIMIT = 4'd12;

    localparam int MGMT_MDC_BIT = 2;
    localparam int RXC_FDX_BIT  = 7;
    localparam int GEN_EN_BIT   = 0;

    typedef struct packed {
        logic mdc;
        logic oe;
        logic dout;
    } mgmt_t;

    typedef struct packed {
        logic [47:0]       sta0;
        logic [47:0]       sta1;
        logic [63:0]       grp;
        logic [WORD_W-1:0] gen;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] tx;
        mgmt_t             mgmt;
    } reg_view_t;

    // Station address high words keep only two bytes.
    function automatic logic [WORD_W-1:0] wr_mask(logic [3:0] ix);
        if (ix == IX_STA0_HI || ix == IX_STA1_HI)
            return 32'h0000_FFFF;
        return '1;
    endfunction

endpackage

// File: rtl/macreg_regs.sv
module macreg_regs
    import macreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              line_lvl,
    output reg_view_t         view_o,
    output logic              chk_req
);

    logic [3:0]        wr_ix, rd_ix;
    logic              wr_dec, rd_dec, wr_hit;
    logic [WORD_W-1:0] word_q [NUM_STORED];
    logic              unused_lsbs;

    assign wr_ix  = wr_addr[5:2];
    assign rd_ix  = rd_addr[5:2];
    assign wr_dec = (wr_addr[ADDR_W-1:6] == '0) && (wr_ix < IX_LIMIT);
    assign rd_dec = (rd_addr[ADDR_W-1:6] == '0) && (rd_ix < IX_LIMIT);
    assign wr_hit = wr_en && wr_dec;
    assign unused_lsbs = ^{wr_addr[1:0], rd_addr[1:0]};

    for (genvar i = 0; i < NUM_STORED; i++) begin : g_word
        localparam logic [3:0] IX = 4'(i);
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_hit && wr_ix == IX)
                q <= wr_data & wr_mask(IX);
        end
        assign word_q[i] = q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_dec) begin
            if (rd_ix == IX_STAT)
                rd_data = {{(WORD_W-1){1'b0}}, line_lvl};
            else
                rd_data = word_q[rd_ix];
        end
    end

    // Check request: receive-control write or management clock level change.
    assign chk_req = wr_hit &&
        ((wr_ix == IX_RXC) ||
         (wr_ix == IX_MGMT &&
          wr_data[MGMT_MDC_BIT] != word_q[IX_MGMT][MGMT_MDC_BIT]));

    assign view_o.sta0 = {word_q[IX_STA0_HI][15:0], word_q[IX_STA0_LO]};
    assign view_o.sta1 = {word_q[IX_STA1_HI][15:0], word_q[IX_STA1_LO]};
    assign view_o.grp  = {word_q[IX_GRP_HI], word_q[IX_GRP_LO]};
    assign view_o.gen  = word_q[IX_GEN];
    assign view_o.rx   = word_q[IX_RXC];
    assign view_o.tx   = word_q[IX_TXC];
    assign view_o.mgmt = mgmt_t'(word_q[IX_MGMT][2:0]);

    AST_UNDEC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dec) |=> $stable(view_o)); // R10

endmodule

// File: rtl/macreg_mdio_io.sv
module macreg_mdio_io
    import macreg_pkg::*;
(
    input  mgmt_t mgmt,
    input  logic  mdio_in,
    output logic  mdc,
    output logic  mdio_out,
    output logic  mdio_oe,
    output logic  line_lvl
);

    assign mdc      = mgmt.mdc;
    assign mdio_out = mgmt.dout;
    assign mdio_oe  = mgmt.oe;
    assign line_lvl = mgmt.oe ? mgmt.dout : mdio_in;

endmodule

// File: rtl/macreg_dpx_mon.sv
module macreg_dpx_mon (
    input  logic clk,
    input  logic rst,
    input  logic chk_req,
    input  logic mac_en,
    input  logic mac_fdx,
    input  logic phy_fdx,
    output logic mismatch,
    output logic changed
);

    logic pend_q;
    logic verdict;

    assign verdict = mac_fdx ^ phy_fdx;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            mismatch <= 1'b0;
            changed  <= 1'b0;
        end else begin
            pend_q  <= chk_req;
            changed <= 1'b0;
            if (pend_q && mac_en) begin
                mismatch <= verdict;
                changed  <= (verdict != mismatch);
            end
        end
    end

    AST_MM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(pend_q && mac_en) |=> $stable(mismatch)); // R7

    AST_MM_EVAL: assert property (@(posedge clk) disable iff (rst)
        (pend_q && mac_en) |=> (mismatch == $past(mac_fdx != phy_fdx))); // R6

    AST_CHG_REAL: assert property (@(posedge clk) disable iff (rst)
        changed |-> (mismatch != $past(mismatch))); // R9

endmodule

// File: rtl/macreg_dpx.sv
module macreg_dpx
    import macreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              mdio_in,
    input  logic              phy_fdx,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [47:0]       sta0_addr,
    output logic [47:0]       sta1_addr,
    output logic [63:0]       grp_table,
    output logic [31:0]       gen_ctrl,
    output logic [31:0]       rx_ctrl,
    output logic [31:0]       tx_ctrl,
    output logic              dpx_mismatch,
    output logic              dpx_changed
);

    reg_view_t view;
    logic      line_lvl;
    logic      chk_req;

    macreg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .line_lvl (line_lvl),
        .view_o   (view),
        .chk_req  (chk_req)
    );

    macreg_mdio_io u_mdio (
        .mgmt     (view.mgmt),
        .mdio_in  (mdio_in),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .line_lvl (line_lvl)
    );

    macreg_dpx_mon u_mon (
        .clk      (clk),
        .rst      (rst),
        .chk_req  (chk_req),
        .mac_en   (view.gen[GEN_EN_BIT]),
        .mac_fdx  (view.rx[RXC_FDX_BIT]),
        .phy_fdx  (phy_fdx),
        .mismatch (dpx_mismatch),
        .changed  (dpx_changed)
    );

    assign sta0_addr = view.sta0;
    assign sta1_addr = view.sta1;
    assign grp_table = view.grp;
    assign gen_ctrl  = view.gen;
    assign rx_ctrl   = view.rx;
    assign tx_ctrl   = view.tx;

    AST_MDC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[ADDR_W-1:2] == ADDR_W'(IX_MGMT)) |=> (mdc == $past(wr_data[2]))); // R4

    AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[ADDR_W-1:2] == ADDR_W'(IX_STAT)) |-> (rd_data[31:1] == '0)); // R5

endmodule

// File: tb/macreg_dpx_tb.sv
module macreg_dpx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mdio_in = 1'b0;
    logic        phy_fdx = 1'b1;
    logic        mdc, mdio_out, mdio_oe;
    logic [47:0] sta0_addr, sta1_addr;
    logic [63:0] grp_table;
    logic [31:0] gen_ctrl, rx_ctrl, tx_ctrl;
    logic        dpx_mismatch, dpx_changed;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    macreg_dpx #(.ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mdio_in(mdio_in), .phy_fdx(phy_fdx),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .sta0_addr(sta0_addr), .sta1_addr(sta1_addr), .grp_table(grp_table),
        .gen_ctrl(gen_ctrl), .rx_ctrl(rx_ctrl), .tx_ctrl(tx_ctrl),
        .dpx_mismatch(dpx_mismatch), .dpx_changed(dpx_changed)
    );

    // {byte address, write data, expected readback}
    localparam logic [71:0] VEC [9] = '{
        {8'h00, 32'h1122_3344, 32'h1122_3344},
        {8'h04, 32'hDEAD_BEEF, 32'h0000_BEEF},
        {8'h08, 32'hA1B2_C3D4, 32'hA1B2_C3D4},
        {8'h0C, 32'h1234_5566, 32'h0000_5566},
        {8'h10, 32'h8000_0001, 32'h8000_0001},
        {8'h14, 32'h0000_F00F, 32'h0000_F00F},
        {8'h1C, 32'h0000_005A, 32'h0000_005A},
        {8'h20, 32'h0000_0C03, 32'h0000_0C03},
        {8'h24, 32'hFFFF_0000, 32'hFFFF_0000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 11; i++) begin
            rd(8'(i * 4), v);
            chk("R1 reset word", 64'(v), 64'h0);
        end
        chk("R1 reset pins", {61'h0, mdc, mdio_out, mdio_oe}, 64'h0);
        chk("R1 reset flag", {62'h0, dpx_mismatch, dpx_changed}, 64'h0);

        // R2/R3/R11 table walk
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk("R2 R3 readback", 64'(v), 64'(VEC[i][31:0]));
        end
        chk("R3 sta0", 64'(sta0_addr), 64'h0000_BEEF_1122_3344);
        chk("R3 sta0 byte0", 64'(sta0_addr[7:0]), 64'h44);
        chk("R3 sta1", 64'(sta1_addr), 64'h0000_5566_A1B2_C3D4);
        chk("R11 grp", grp_table, 64'h0000_F00F_8000_0001);
        chk("R2 rx/tx ports", {rx_ctrl, tx_ctrl}, {32'h5A, 32'hC03});
        chk("R7 flag held while disabled", 64'(dpx_mismatch), 64'h0);

        // R2 low address bits ignored
        wr(8'h23, 32'h77);
        rd(8'h21, v);
        chk("R2 lsb ignored", 64'(v), 64'h77);

        // R10 undecoded writes
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        chk("R10 sta0 unchanged", 64'(sta0_addr), 64'h0000_BEEF_1122_3344);
        rd(8'h30, v); chk("R10 read idx12", 64'(v), 64'h0);
        rd(8'h40, v); chk("R10 read high addr", 64'(v), 64'h0);

        // R4/R5 management bit-bang
        wr(8'h28, 32'h7);
        chk("R4 pins", {61'h0, mdc, mdio_oe, mdio_out}, 64'h7);
        rd(8'h2C, v); chk("R5 driven line", 64'(v), 64'h1);
        rd(8'h28, v); chk("R2 mgmt readback", 64'(v), 64'h7);
        wr(8'h28, 32'h4);
        chk("R4 oe off", {61'h0, mdc, mdio_oe, mdio_out}, 64'h4);
        rd(8'h2C, v); chk("R5 line from pin 0", 64'(v), 64'h0);
        mdio_in = 1'b1;
        rd(8'h2C, v); chk("R5 line from pin 1", 64'(v), 64'h1);
        wr(8'h2C, 32'hFFFF_FFFE);
        mdio_in = 1'b0;
        rd(8'h2C, v); chk("R5 status write ignored", 64'(v), 64'h0);
        chk("R7 flag after mdc toggle disabled", 64'(dpx_mismatch), 64'h0);

        // R8 general control write starts no check (phy=1, mac fdx=0)
        wr(8'h18, 32'h1);
        @(negedge clk); @(negedge clk);
        chk("R8 gen write no check", 64'(dpx_mismatch), 64'h0);

        // R6/R9 receive-control write check
        wr(8'h1C, 32'h5A);
        chk("R6 not yet at first edge", 64'(dpx_mismatch), 64'h0);
        @(negedge clk);
        chk("R6 rx check sets flag", 64'(dpx_mismatch), 64'h1);
        chk("R9 pulse on set", 64'(dpx_changed), 64'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", 64'(dpx_changed), 64'h0);

        // R8 mgmt write keeping mdc level
        phy_fdx = 1'b0;
        wr(8'h28, 32'h5);
        @(negedge clk); @(negedge clk);
        chk("R8 same mdc no check", {62'h0, dpx_mismatch, dpx_changed}, 64'h2);

        // R6 mdc change starts check
        wr(8'h28, 32'h0);
        chk("R4 mdc low", 64'(mdc), 64'h0);
        @(negedge clk);
        chk("R6 mdc check clears flag", {62'h0, dpx_mismatch, dpx_changed}, 64'h1);

        // R7 disabled check
        wr(8'h18, 32'h0);
        phy_fdx = 1'b1;
        wr(8'h1C, 32'h0);
        @(negedge clk); @(negedge clk);
        chk("R7 disabled holds", {62'h0, dpx_mismatch, dpx_changed}, 64'h0);

        // R9 confirming check gives no pulse
        wr(8'h18, 32'h1);
        wr(8'h1C, 32'h80);
        @(negedge clk);
        chk("R9 no pulse on match", {62'h0, dpx_mismatch, dpx_changed}, 64'h0);
        phy_fdx = 1'b0;
        wr(8'h1C, 32'h80);
        @(negedge clk);
        chk("R6 mac full phy half", {62'h0, dpx_mismatch, dpx_changed}, 64'h3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule